// File: doc/BRIEF.md
# UART Transmit Byte Queue with Fill Threshold

This block buffers outgoing bytes for a UART transmitter. Each register write strobe delivers one byte, which is appended to a circular buffer of `DEPTH` entries (32 by default). The serializer downstream takes bytes from the head with a valid/ready handshake. It can only take bytes while the transmit enable input is high.

The block drives a live fill level and full and empty status flags. It also drives a fill-threshold flag that is compared against an encoded threshold select, plus two one-cycle events: one when a transmission drains the queue to nothing, and one when a write is lost because the queue was full. A flush input empties the queue at once. All outputs are registered or are decoded directly from registered state. They reflect the clock edge where the stimulus was sampled.

Top module: `uart_tx_fifo`

## Requirements
- R1: A write strobe with flush low and space available appends its byte. Bytes leave at `head_o` in the order they were written.
- R2: A write while `full_o` is high and no pop happens in the same cycle is discarded and the contents stay as they were. `ovf_evt_o` pulses for exactly the following cycle. A write while full that coincides with a pop is accepted.
- R3: `full_o` is high exactly when the level equals `DEPTH`. It drops in the cycle after a single pop.
- R4: After reset the level is 0, `empty_o` is 1, and `full_o`, `wmark_o`, `head_valid_o` and both events are 0. `empty_o` is high exactly when the level is 0.
- R5: An accepted write and a pop in the same cycle leave the level unchanged.
- R6: With `tx_en_i` low, `head_valid_o` is 0 and `ready_i` has no effect on the level.
- R7: The threshold select `thr_sel_i` decodes as follows: 0 gives 1, 1 gives 4, 2 gives 8, 3 gives 16, and 4 to 7 give `DEPTH`-2 (30 by default).
- R8: `wmark_o` sets only at an accepted write after which the level is at or above the decoded threshold. Changing the threshold alone never sets it.
- R9: `wmark_o` clears in any cycle where the new level is below the decoded threshold, and it clears on a flush.
- R10: `empty_evt_o` pulses for one cycle after a pop takes the level from 1 to 0 without a write in the same cycle. A flush does not raise it.
- R11: `flush_i` forces the level to 0 at the next edge and takes precedence over a write in the same cycle. That write is neither stored nor flagged as an overflow.
- R12: `level_o` is the number of bytes held, in binary, from 0 to `DEPTH`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| wr_en_i | input | 1 | Data register write strobe |
| wr_byte_i | input | 8 | Byte carried by the write |
| thr_sel_i | input | 3 | Encoded fill threshold |
| flush_i | input | 1 | Empty the queue |
| tx_en_i | input | 1 | Transmit enable, gates draining |
| ready_i | input | 1 | Serializer takes the head byte |
| head_o | output | 8 | Oldest byte held |
| head_valid_o | output | 1 | Head byte offered to serializer |
| level_o | output | $clog2(DEPTH+1) | Number of bytes held |
| full_o | output | 1 | Level equals DEPTH |
| empty_o | output | 1 | Level is zero |
| wmark_o | output | 1 | Fill-threshold flag |
| empty_evt_o | output | 1 | One-cycle pulse on drain to zero |
| ovf_evt_o | output | 1 | One-cycle pulse on a discarded write |

## Verification
A pointer or count that drifts from the true occupancy shows up as a wrong `level_o` or a wrong flag one cycle after the faulty edge, so the level and both flags are compared against a model every cycle. A corrupted storage entry or pointer shows up only when that byte reaches the head. Every popped byte is therefore matched against a queue of expected bytes, which catches reordering, loss or duplication at the moment the byte is handed over. Mistakes in the threshold flag and in the event logic show up as a flag or pulse landing one cycle early, one cycle late, or on the wrong stimulus. That includes a flag raised by a threshold change alone, or a pulse raised by a flush.

// File: rtl/uart_txq_pkg.sv
package uart_txq_pkg;

  // Encoded threshold select to fill level
  function automatic int unsigned thr_decode(input logic [2:0] sel, input int unsigned depth);
    int unsigned r;
    if (sel == 3'd0)      r = 1;
    else if (sel[2])      r = depth - 2;
    else                  r = 1 << (int'(sel) + 1);
    return r;
  endfunction

endpackage

// File: rtl/txq_mem.sv
module txq_mem #(
  parameter int unsigned DEPTH = 32,
  parameter int unsigned DW    = 8,
  localparam int unsigned AW   = $clog2(DEPTH)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          push_i,
  input  logic          pop_i,
  input  logic          flush_i,
  input  logic [DW-1:0] wdata_i,
  output logic [DW-1:0] head_o
);

  logic [DW-1:0] mem_q [DEPTH];
  logic [AW-1:0] wptr_q, rptr_q, wptr_inc, rptr_inc;

  generate
    if ((1 << AW) == DEPTH) begin : g_pow2
      assign wptr_inc = wptr_q + 1'b1;
      assign rptr_inc = rptr_q + 1'b1;
    end else begin : g_wrap
      assign wptr_inc = (wptr_q == AW'(DEPTH-1)) ? '0 : wptr_q + 1'b1;
      assign rptr_inc = (rptr_q == AW'(DEPTH-1)) ? '0 : rptr_q + 1'b1;
    end
  endgenerate

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wptr_q <= '0;
      rptr_q <= '0;
    end else if (flush_i) begin
      wptr_q <= '0;
      rptr_q <= '0;
    end else begin
      if (push_i) wptr_q <= wptr_inc;
      if (pop_i)  rptr_q <= rptr_inc;
    end
  end

  always_ff @(posedge clk_i) begin
    if (push_i) mem_q[wptr_q] <= wdata_i;
  end

  assign head_o = mem_q[rptr_q];

  // R1: a pop without flush always advances the read side
  p_rptr_adv_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pop_i && !flush_i) |=> (rptr_q != $past(rptr_q)));

endmodule

// File: rtl/txq_level.sv
module txq_level #(
  parameter int unsigned DEPTH = 32,
  localparam int unsigned LW   = $clog2(DEPTH+1)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          push_i,
  input  logic          pop_i,
  input  logic          flush_i,
  output logic [LW-1:0] level_o,
  output logic [LW-1:0] level_nxt_o,
  output logic          full_o,
  output logic          empty_o
);

  logic [LW-1:0] level_q;

  always_comb begin
    level_nxt_o = level_q;
    if (flush_i) level_nxt_o = '0;
    else begin
      unique case ({push_i, pop_i})
        2'b10:   level_nxt_o = level_q + 1'b1;
        2'b01:   level_nxt_o = level_q - 1'b1;
        default: level_nxt_o = level_q;
      endcase
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) level_q <= '0;
    else         level_q <= level_nxt_o;
  end

  assign level_o = level_q;
  assign full_o  = (level_q == LW'(DEPTH));
  assign empty_o = (level_q == '0);

  p_bound_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    level_q <= LW'(DEPTH));

  p_pushpop_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (push_i && pop_i && !flush_i) |=> $stable(level_q));

  p_flush_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    flush_i |=> (level_q == '0));

endmodule

// File: rtl/txq_events.sv
module txq_events #(
  parameter int unsigned DEPTH = 32,
  localparam int unsigned LW   = $clog2(DEPTH+1)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          push_i,
  input  logic          drop_i,
  input  logic          flush_i,
  input  logic [LW-1:0] level_i,
  input  logic [LW-1:0] level_nxt_i,
  input  logic [LW-1:0] thr_i,
  output logic          wmark_o,
  output logic          empty_evt_o,
  output logic          ovf_evt_o
);

  logic wmark_q, empty_evt_q, ovf_evt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wmark_q     <= 1'b0;
      empty_evt_q <= 1'b0;
      ovf_evt_q   <= 1'b0;
    end else begin
      if (flush_i || level_nxt_i < thr_i) wmark_q <= 1'b0;
      else if (push_i)                    wmark_q <= 1'b1;
      // drain to zero by transmission only
      empty_evt_q <= !flush_i && level_i != '0 && level_nxt_i == '0;
      ovf_evt_q   <= drop_i;
    end
  end

  assign wmark_o     = wmark_q;
  assign empty_evt_o = empty_evt_q;
  assign ovf_evt_o   = ovf_evt_q;

  p_wmark_set_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(wmark_q) |-> $past(push_i));

  p_empty_evt_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    empty_evt_q |-> (level_i == '0 && $past(level_i) == LW'(1)));

  p_no_overflow_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ovf_evt_q |-> (level_i == $past(level_i)));

endmodule

// File: rtl/uart_tx_fifo.sv
module uart_tx_fifo #(
  parameter int unsigned DEPTH = 32,
  parameter int unsigned DW    = 8,
  localparam int unsigned LW   = $clog2(DEPTH+1)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          wr_en_i,
  input  logic [DW-1:0] wr_byte_i,
  input  logic [2:0]    thr_sel_i,
  input  logic          flush_i,
  input  logic          tx_en_i,
  input  logic          ready_i,
  output logic [DW-1:0] head_o,
  output logic          head_valid_o,
  output logic [LW-1:0] level_o,
  output logic          full_o,
  output logic          empty_o,
  output logic          wmark_o,
  output logic          empty_evt_o,
  output logic          ovf_evt_o
);

  logic          push, pop, drop;
  logic [LW-1:0] level_nxt, thr;

  assign thr          = LW'(uart_txq_pkg::thr_decode(thr_sel_i, DEPTH));
  assign head_valid_o = tx_en_i && !empty_o;
  assign pop          = head_valid_o && ready_i && !flush_i;
  assign push         = wr_en_i && !flush_i && (!full_o || pop);
  assign drop         = wr_en_i && !flush_i && full_o && !pop;

  txq_mem #(.DEPTH(DEPTH), .DW(DW)) u_mem (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .push_i  (push),
    .pop_i   (pop),
    .flush_i (flush_i),
    .wdata_i (wr_byte_i),
    .head_o  (head_o)
  );

  txq_level #(.DEPTH(DEPTH)) u_level (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .push_i      (push),
    .pop_i       (pop),
    .flush_i     (flush_i),
    .level_o     (level_o),
    .level_nxt_o (level_nxt),
    .full_o      (full_o),
    .empty_o     (empty_o)
  );

  txq_events #(.DEPTH(DEPTH)) u_events (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .push_i      (push),
    .drop_i      (drop),
    .flush_i     (flush_i),
    .level_i     (level_o),
    .level_nxt_i (level_nxt),
    .thr_i       (thr),
    .wmark_o     (wmark_o),
    .empty_evt_o (empty_evt_o),
    .ovf_evt_o   (ovf_evt_o)
  );

  p_tx_gate_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!tx_en_i && !wr_en_i && !flush_i) |=> $stable(level_o));

endmodule

// File: tb/uart_tx_fifo_tb.sv
module uart_tx_fifo_tb_top;
  localparam int DEPTH = 32;
  localparam int LW = $clog2(DEPTH+1);

  logic clk = 1'b0, rst_n = 1'b0;
  logic wr_en = 1'b0, flush = 1'b0, tx_en = 1'b0, ready = 1'b0;
  logic [7:0] wr_byte = '0;
  logic [2:0] thr_sel = '0;
  logic [7:0] head;
  logic head_valid, full, empty, wmark, empty_evt, ovf_evt;
  logic [LW-1:0] level;

  int checks = 0, fails = 0;
  int m_lvl = 0;
  bit m_wm = 0;
  byte unsigned q[$];

  always #2.5 clk = ~clk;

  uart_tx_fifo #(.DEPTH(DEPTH)) dut_i (
    .clk_i(clk), .rst_ni(rst_n), .wr_en_i(wr_en), .wr_byte_i(wr_byte),
    .thr_sel_i(thr_sel), .flush_i(flush), .tx_en_i(tx_en), .ready_i(ready),
    .head_o(head), .head_valid_o(head_valid), .level_o(level), .full_o(full),
    .empty_o(empty), .wmark_o(wmark), .empty_evt_o(empty_evt), .ovf_evt_o(ovf_evt)
  );

  function automatic int thr_of(input logic [2:0] s);
    case (s)
      3'd0: return 1;
      3'd1: return 4;
      3'd2: return 8;
      3'd3: return 16;
      default: return 30;
    endcase
  endfunction

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // monitor: compare every byte handed to the serializer
  always @(negedge clk) begin
    if (rst_n && head_valid && ready && !flush) begin
      checks++;
      if (q.size() == 0) begin
        fails++;
        $display("FAIL R1 actual=%0d expected=none", head);
      end else begin
        if (head != q[0]) begin
          fails++;
          $display("FAIL R1 actual=%0d expected=%0d", head, q[0]);
        end
        void'(q.pop_front());
      end
    end
  end

  // driver: one cycle of stimulus, model update and output checks
  task automatic step(input bit w, input byte unsigned b, input bit r, input bit f);
    bit pop, acc, drop, eevt;
    int nl;
    wr_en = w; wr_byte = b; ready = r; flush = f;
    pop  = tx_en && r && m_lvl > 0 && !f;
    acc  = w && !f && (m_lvl < DEPTH || pop);
    drop = w && !f && m_lvl == DEPTH && !pop;
    nl   = f ? 0 : m_lvl + int'(acc) - int'(pop);
    eevt = !f && m_lvl != 0 && nl == 0;
    if (f || nl < thr_of(thr_sel)) m_wm = 0;
    else if (acc) m_wm = 1;
    @(posedge clk); #1;
    m_lvl = nl;
    if (f) q.delete();
    if (acc) q.push_back(b);
    chk("R12 level", int'(level), m_lvl);
    chk("R3 full", int'(full), int'(m_lvl == DEPTH));
    chk("R4 empty", int'(empty), int'(m_lvl == 0));
    chk("R8/R9 wmark", int'(wmark), int'(m_wm));
    chk("R2 ovf_evt", int'(ovf_evt), int'(drop));
    chk("R10 empty_evt", int'(empty_evt), int'(eevt));
    chk("R6 head_valid", int'(head_valid), int'(tx_en && m_lvl > 0));
    wr_en = 0; flush = 0;
  endtask

  initial begin
    #2000000;
    fails++; checks++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    #12 rst_n = 1'b1;
    @(posedge clk); #1;
    // R4 reset state
    chk("R4 level", int'(level), 0);
    chk("R4 empty", int'(empty), 1);
    chk("R4 full", int'(full), 0);
    chk("R4 wmark", int'(wmark), 0);
    chk("R4 valid", int'(head_valid), 0);
    chk("R4 events", int'(empty_evt) + int'(ovf_evt), 0);

    // R7 threshold 8; fill with tx off and ready high (R6)
    thr_sel = 3'd2; tx_en = 0;
    for (int i = 0; i < DEPTH; i++) step(1, byte'(i*7+3), 1, 0);
    // R2 write while full is dropped
    step(1, 8'hEE, 0, 0);
    step(0, 0, 1, 0);
    // R7 threshold 30 (select 5), drain: full clears, wmark clears below 30
    thr_sel = 3'd5;
    tx_en = 1;
    for (int i = 0; i < DEPTH + 2; i++) step(0, 0, 1, 0);

    // R8 threshold change alone does not set wmark
    tx_en = 0; thr_sel = 3'd1;
    for (int i = 0; i < 3; i++) step(1, byte'(8'h40+i), 0, 0);
    thr_sel = 3'd0;
    step(0, 0, 0, 0);
    step(0, 0, 0, 0);
    chk("R8 no set by thr change", int'(wmark), 0);
    step(1, 8'h55, 0, 0);
    chk("R8 set on write", int'(wmark), 1);
    thr_sel = 3'd3;
    step(0, 0, 0, 0);

    // R5 simultaneous write and pop
    tx_en = 1;
    for (int i = 0; i < 6; i++) step(1, byte'(8'h80+i), 1, 0);
    chk("R5 level kept", int'(level), 4);

    // R11 flush beats write, R9 wmark cleared
    thr_sel = 3'd1;
    step(1, 8'h11, 0, 0);
    chk("R9 wmark before flush", int'(wmark), 1);
    step(1, 8'h99, 0, 1);
    chk("R11 flush level", int'(level), 0);

    // R2 write while full with a pop is accepted
    tx_en = 0; thr_sel = 3'd4;
    for (int i = 0; i < DEPTH; i++) step(1, byte'(255-i), 0, 0);
    tx_en = 1;
    step(1, 8'hA5, 1, 0);
    chk("R2 full+pop accepted", int'(level), DEPTH);
    step(1, 8'hA6, 0, 0);
    for (int i = 0; i < DEPTH + 2; i++) step(0, 0, 1, 0);
    chk("R1 all bytes delivered", q.size(), 0);

    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule